// File: doc/BRIEF.md
# Dual-Pointer Memory Address Generator

This unit forms the address of every memory access issued by a small pipelined processor. Two 16-bit pointers live in one small register file: entry 0 is the program counter and entry 1 is the address pointer for direct memory transfers. Each access cycle, the unit picks an entry based on the kind of access. It computes the address from that pointer and the control flags, and writes the new value back into the same entry. Because of this shared storage, the direct-transfer engine needs no counter or address multiplexer of its own.

Fetch cycles can advance sequentially, follow a taken branch, or follow a jump. A fetch or transfer cycle can also force its pointer to zero. Load/store cycles take their address from the datapath adder and leave both pointers alone. Pointer updates only happen when the address clock enable is high. A return-address register tracks the address of the instruction now in the decode stage, so that a jump can store it as a link value.

Top module: `dual_ptr_agu`

## Requirements
- R1: `cyc_i` encodes the access kind as follows: 2'b00 is an instruction fetch and uses pointer entry 0. 2'b01 is a direct transfer and uses entry 1. 2'b10 is a load/store. 2'b11 is handled the same as 2'b10.
- R2: A fetch with no zero, jump or branch request presents the program counter plus 2 on `addr_o` and `wb_o`. When `ace_i` is high, that value is stored back as the program counter.
- R3: A fetch with `branch_i` high and no jump or zero request presents the program counter plus twice the sign-extended 8-bit `disp_i`. It stores that value back when `ace_i` is high.
- R4: A fetch with `jump_i` high and no zero request presents `sum_i` and stores it as the program counter when `ace_i` is high. A jump wins over a branch.
- R5: A load/store cycle presents `sum_i` on `addr_o` and the current program counter on `wb_o`. It changes neither pointer.
- R6: A direct-transfer cycle presents the transfer pointer plus 2 and stores it back when `ace_i` is high. It ignores `branch_i` and `jump_i` and leaves the program counter unchanged.
- R7: A fetch or transfer cycle with `zero_i` high presents address 0 and clears the selected pointer when `ace_i` is high. The zero request wins over jump and branch.
- R8: While `ace_i` is low, neither pointer changes, but `addr_o` still shows the address for the current inputs.
- R9: Each fetch issued with `ace_i` high records its address. When `ret_ce_i` is high at a clock edge, `ret_o` takes the most recently recorded fetch address as it stood before that edge.
- R10: After reset, both pointers, the recorded fetch address and `ret_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_i | input | 2 | Kind of the access being issued |
| branch_i | input | 1 | Taken branch applies to this fetch |
| jump_i | input | 1 | Jump or call applies to this fetch |
| zero_i | input | 1 | Force the selected pointer to zero |
| ace_i | input | 1 | Address clock enable; commits pointer updates |
| disp_i | input | 8 | Signed branch displacement in words |
| sum_i | input | 16 | Adder result from the datapath |
| ret_ce_i | input | 1 | Pipeline advance; loads the return address |
| addr_o | output | 16 | Memory address for this access |
| wb_o | output | 16 | Value written back to the selected pointer |
| ret_o | output | 16 | Address of the decode-stage instruction |

## Verification
The bench targets the corners where the two pointers could interfere. It runs load/store and transfer cycles between fetches and confirms that the program counter resumes exactly where it stopped; a wrong entry select or a stray write would make the next fetch address jump. It applies negative displacements, which catch a design that zero-extends them or forgets to double them. It raises jump and branch together, and zero with jump, to expose a wrong priority order. It drops `ace_i` for several cycles to catch updates that commit without the enable. It also checks that the return address lags one fetch behind, which a design latching the live address would fail.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_DMA   = 2'b01,
    CYC_LDST  = 2'b10,
    CYC_RSVD  = 2'b11
  } cyc_e;

  localparam int unsigned PC_IDX  = 0;
  localparam int unsigned DMA_IDX = 1;
endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] dma_o
);
  logic [AW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
  assign pc_o    = mem_q[agu_pkg::PC_IDX];
  assign dma_o   = mem_q[agu_pkg::DMA_IDX];
endmodule

// File: rtl/agu_next_addr.sv
module agu_next_addr
  import agu_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  cyc_e          cyc_i,
  input  logic          branch_i,
  input  logic          jump_i,
  input  logic          zero_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] sum_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] addr_o,
  output logic          upd_o
);
  logic [AW-1:0] boff;
  assign boff = {{(AW-DW-1){disp_i[DW-1]}}, disp_i, 1'b0};

  always_comb begin
    upd_o  = 1'b0;
    addr_o = ptr_i + AW'(2);
    unique case (cyc_i)
      CYC_FETCH: begin
        upd_o = 1'b1;
        if (zero_i)        addr_o = '0;
        else if (jump_i)   addr_o = sum_i;
        else if (branch_i) addr_o = ptr_i + boff;
        else               addr_o = ptr_i + AW'(2);
      end
      CYC_DMA: begin
        upd_o  = 1'b1;
        addr_o = zero_i ? '0 : ptr_i + AW'(2);
      end
      default: begin
        upd_o  = 1'b0;
        addr_o = sum_i;
      end
    endcase
  end
endmodule

// File: rtl/agu_ret_reg.sv
module agu_ret_reg #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ret_ce_i,
  output logic [AW-1:0] ret_o
);
  logic [AW-1:0] ifa_q, ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifa_q <= '0;
      ret_q <= '0;
    end else begin
      if (cap_i)    ifa_q <= addr_i;
      if (ret_ce_i) ret_q <= ifa_q;
    end
  end

  assign ret_o = ret_q;

  AST_RET_LAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_ce_i |=> ret_o == $past(ifa_q)); // R9
  AST_RET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_ce_i |=> $stable(ret_o)); // R9
endmodule

// File: rtl/dual_ptr_agu.sv
module dual_ptr_agu
  import agu_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned PTR_DEPTH = 16,
  localparam int unsigned IW       = $clog2(PTR_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cyc_i,
  input  logic          branch_i,
  input  logic          jump_i,
  input  logic          zero_i,
  input  logic          ace_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] sum_i,
  input  logic          ret_ce_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] wb_o,
  output logic [AW-1:0] ret_o
);
  cyc_e          cyc;
  logic [IW-1:0] idx;
  logic [AW-1:0] ptr_rd, pc_w, dma_w, nxt;
  logic          upd;

  assign cyc = cyc_e'(cyc_i);
  assign idx = (cyc == CYC_DMA) ? IW'(DMA_IDX) : IW'(PC_IDX);

  agu_ptr_file #(.AW(AW), .DEPTH(PTR_DEPTH)) u_ptrs (
    .clk_i, .rst_ni,
    .we_i   (upd & ace_i),
    .idx_i  (idx),
    .wdata_i(nxt),
    .rdata_o(ptr_rd),
    .pc_o   (pc_w),
    .dma_o  (dma_w)
  );

  agu_next_addr #(.AW(AW), .DW(DW)) u_next (
    .cyc_i   (cyc),
    .branch_i, .jump_i, .zero_i, .disp_i, .sum_i,
    .ptr_i   (ptr_rd),
    .addr_o  (nxt),
    .upd_o   (upd)
  );

  agu_ret_reg #(.AW(AW)) u_ret (
    .clk_i, .rst_ni,
    .cap_i   (ace_i && cyc == CYC_FETCH),
    .addr_i  (nxt),
    .ret_ce_i,
    .ret_o
  );

  assign addr_o = nxt;
  assign wb_o   = upd ? nxt : pc_w;

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ace_i && cyc == CYC_FETCH && !zero_i && !jump_i && !branch_i)
      |=> pc_w == $past(pc_w) + AW'(2)); // R2
  AST_LDST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i[1]) |=> $stable(pc_w) && $stable(dma_w)); // R5
  AST_DMA_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ace_i && cyc == CYC_DMA && !zero_i)
      |=> dma_w == $past(dma_w) + AW'(2) && $stable(pc_w)); // R6
  AST_ZERO_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ace_i && zero_i && cyc == CYC_FETCH) |=> pc_w == '0); // R7
  AST_NO_ACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ace_i |=> $stable(pc_w) && $stable(dma_w)); // R8
endmodule

// File: tb/dual_ptr_agu_test.sv
`timescale 1ns/1ps
module dual_ptr_agu_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cyc_i = 2'b00;
  logic        branch_i = 1'b0, jump_i = 1'b0, zero_i = 1'b0, ace_i = 1'b0;
  logic        ret_ce_i = 1'b0;
  logic [7:0]  disp_i = '0;
  logic [15:0] sum_i = '0;
  logic [15:0] addr_o, wb_o, ret_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] e_pc = '0, e_dma = '0, e_ifa = '0, e_ret = '0;

  always #5 clk = ~clk;

  dual_ptr_agu uut (
    .clk_i(clk), .rst_ni, .cyc_i, .branch_i, .jump_i, .zero_i, .ace_i,
    .disp_i, .sum_i, .ret_ce_i, .addr_o, .wb_o, .ret_o
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // One access cycle: drive, check combinational outputs, clock, update model.
  task automatic step(input logic [1:0] k, input logic br, input logic jp, input logic zr,
                      input logic ac, input logic rc, input logic [7:0] d,
                      input logic [15:0] s, input string tag);
    logic [15:0] ea, ew;
    @(negedge clk);
    cyc_i = k; branch_i = br; jump_i = jp; zero_i = zr; ace_i = ac;
    ret_ce_i = rc; disp_i = d; sum_i = s;
    #1;
    if (k[1]) begin ea = s; ew = e_pc; end
    else if (zr) begin ea = '0; ew = '0; end
    else if (k == 2'b01) begin ea = e_dma + 16'd2; ew = ea; end
    else if (jp) begin ea = s; ew = ea; end
    else if (br) begin ea = e_pc + {{7{d[7]}}, d, 1'b0}; ew = ea; end
    else begin ea = e_pc + 16'd2; ew = ea; end
    chk(tag, "addr_o", addr_o, ea);
    chk(tag, "wb_o", wb_o, ew);
    chk("R9", "ret_o", ret_o, e_ret);
    @(posedge clk);
    if (rc) e_ret = e_ifa;
    if (ac && k == 2'b00) begin e_pc = ea; e_ifa = ea; end
    if (ac && k == 2'b01) e_dma = ea;
  endtask

  task automatic t_reset();
    step(2'b00, 0, 0, 0, 0, 0, 8'h00, 16'h0000, "R10");
    step(2'b01, 0, 0, 0, 0, 0, 8'h00, 16'h0000, "R10");
  endtask

  task automatic t_seq();
    for (int i = 0; i < 4; i++) step(2'b00, 0, 0, 0, 1, 0, 8'h00, 16'h0, "R2");
  endtask

  task automatic t_branch();
    step(2'b00, 1, 0, 0, 1, 0, 8'h05, 16'h0, "R3");
    step(2'b00, 1, 0, 0, 1, 0, 8'hFE, 16'h0, "R3");
    step(2'b00, 1, 0, 0, 1, 0, 8'h80, 16'h0, "R3");
    step(2'b00, 0, 0, 0, 1, 0, 8'h00, 16'h0, "R2");
  endtask

  task automatic t_jump();
    step(2'b00, 0, 1, 0, 1, 0, 8'h00, 16'h1230, "R4");
    step(2'b00, 1, 1, 0, 1, 0, 8'h7F, 16'h4400, "R4");
    step(2'b00, 0, 0, 0, 1, 0, 8'h00, 16'h0, "R4");
  endtask

  task automatic t_ldst();
    step(2'b10, 1, 1, 1, 1, 0, 8'h11, 16'hBEEF, "R5");
    step(2'b11, 0, 0, 0, 1, 0, 8'h00, 16'h0101, "R1");
    step(2'b00, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R5");
  endtask

  task automatic t_dma();
    step(2'b01, 0, 0, 0, 1, 0, 8'h00, 16'h0, "R6");
    step(2'b01, 1, 1, 0, 1, 0, 8'h40, 16'h9999, "R6");
    step(2'b01, 0, 0, 0, 1, 0, 8'h00, 16'h0, "R1");
    step(2'b00, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R6");
  endtask

  task automatic t_zero();
    step(2'b00, 1, 1, 1, 1, 0, 8'h22, 16'h5555, "R7");
    step(2'b00, 0, 0, 0, 1, 0, 8'h00, 16'h0, "R7");
    step(2'b01, 0, 0, 1, 1, 0, 8'h00, 16'h0, "R7");
    step(2'b01, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R7");
  endtask

  task automatic t_noace();
    step(2'b00, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R8");
    step(2'b00, 1, 0, 0, 0, 0, 8'h10, 16'h0, "R8");
    step(2'b01, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R8");
    step(2'b00, 0, 1, 0, 0, 0, 8'h00, 16'h7000, "R8");
    step(2'b00, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R8");
  endtask

  task automatic t_ret();
    step(2'b00, 0, 1, 0, 1, 0, 8'h00, 16'h0800, "R9");
    step(2'b00, 0, 0, 0, 1, 1, 8'h00, 16'h0, "R9");
    step(2'b10, 0, 0, 0, 1, 1, 8'h00, 16'h3333, "R9");
    step(2'b00, 0, 0, 0, 1, 0, 8'h00, 16'h0, "R9");
    step(2'b00, 0, 0, 0, 0, 0, 8'h00, 16'h0, "R9");
  endtask

  initial begin
    #25 rst_ni = 1'b1;
    t_reset();
    t_seq();
    t_branch();
    t_jump();
    t_ldst();
    t_dma();
    t_zero();
    t_noace();
    t_ret();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule